// File: doc/BRIEF.md
# Bus-Master DMA Register Window for a Two-Channel Disk Controller

This block decodes a small I/O window that holds the bus-master control registers of the disk channels. Each channel owns an 8-byte group, channel 0 at offsets 0 to 7 and channel 1 at offsets 8 to 15. The first four bytes of a group are control bytes: a command byte, a mode byte shared by every channel, a status byte and a per-channel transfer timing byte. The upper four bytes hold the physical address of the channel's descriptor table.

A host reaches the window through a plain I/O port: an address, an access size, a read strobe and a write strobe with write data. Read data is registered and comes back one cycle after the read strobe, qualified by a valid flag. A command byte write is also forwarded to the external command handler as a one-cycle strobe per channel. The status byte mixes three write behaviours: two freely writable bits, two sticky flags that the host clears by writing a one and that the transfer engine sets with pulses, and one read-only bit that mirrors the engine's active flag.

Control bytes accept only single-byte accesses. The descriptor address accepts byte, aligned half-word and aligned word accesses. Its two low bits always read as zero.

Top module: `bmw_regwin`

## Requirements
- R1: After reset, every command, status, timing, mode and descriptor address bit reads as zero, `io_rvalid` is low and no command strobe is raised.
- R2: A read raises `io_rvalid` for exactly one cycle, one cycle after `io_rd`. A single-byte read returns its byte in `io_rdata[7:0]` with bits 31:8 zero.
- R3: A control byte (group offsets 0 to 3) accessed with a size other than one byte returns all ones for the access width and ignores writes. Size codes are 0 for one byte, 1 for two bytes, 2 for four bytes, and 3, which is treated as four bytes of ones.
- R4: A byte write to group offset 0 stores the command byte. On the next cycle it pulses `cmd_wstb` for that channel only, with the byte on `cmd_wdata`.
- R5: Group offset 1 of any channel reads one shared mode byte. A write there changes only bits 5:4, and all other bits read zero.
- R6: A status write (group offset 2) loads bits 6:5 from the data, clears bit 1 and bit 2 where the data bit is one, and leaves bit 0 alone.
- R7: Status bit 0 reads the channel's `eng_active` input as sampled with the read. Bits 7, 4 and 3 always read zero.
- R8: An `err_set` pulse sets status bit 1 and an `irq_set` pulse sets status bit 2. When a pulse and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R9: Group offset 3 is a full 8-bit timing byte, separate for each channel.
- R10: Group offsets 4 to 7 hold a little-endian 32-bit descriptor address, written and read by byte, by aligned half-word (offset 4 or 6) or by word (offset 4). Bits 1:0 ignore writes and read zero.
- R11: A misaligned half-word or word access to the descriptor address, or any size-3 access, returns all ones for its width and writes nothing.
- R12: The two channels are independent. An access to one group never changes another channel's command, status, timing or address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | AW (4) | Byte offset within the window |
| io_size | input | 2 | Access size code: 0 byte, 1 half-word, 2 word |
| io_rd | input | 1 | Read strobe |
| io_wr | input | 1 | Write strobe |
| io_wdata | input | 32 | Write data, aligned to bit 0 |
| io_rdata | output | 32 | Registered read data |
| io_rvalid | output | 1 | Read data valid, one cycle after `io_rd` |
| eng_active | input | N_CH | Per-channel transfer engine active flag |
| err_set | input | N_CH | Per-channel error set pulse |
| irq_set | input | N_CH | Per-channel interrupt set pulse |
| cmd_wstb | output | N_CH | Per-channel command write strobe |
| cmd_wdata | output | 8 | Byte carried with the command strobe |

## Verification
The bench builds the block with its default of two channels. This is the smallest count at which the shared mode byte can be written through one group and read through the other, and at which cross-channel leakage of command, timing and address writes can be seen. A behavioural model runs every clock and predicts read data, valid timing and command strobes. Directed sequences cover the status bit collision between a set pulse and a clearing write, wide and misaligned accesses, and the alignment of the descriptor address.

// File: rtl/bmw_pkg.sv
`timescale 1ns/1ps
package bmw_pkg;

    localparam int DW = 32;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;

    // register select produced by the window decoder
    typedef enum logic [2:0] {
        SEL_NONE = 3'd0,
        SEL_CMD  = 3'd1,
        SEL_MODE = 3'd2,
        SEL_STAT = 3'd3,
        SEL_TIME = 3'd4,
        SEL_PTR  = 3'd5
    } bmw_sel_e;

    // all-ones pattern returned for an access of the given width
    function automatic logic [DW-1:0] size_ones(input logic [1:0] sz);
        case (sz)
            SZ_BYTE: size_ones = 32'h0000_00FF;
            SZ_HALF: size_ones = 32'h0000_FFFF;
            default: size_ones = 32'hFFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/bmw_decode.sv
`timescale 1ns/1ps
module bmw_decode
    import bmw_pkg::*;
#(
    parameter int N_CH = 2,
    localparam int CW = (N_CH > 1) ? $clog2(N_CH) : 1,
    localparam int AW = CW + 3
) (
    input  logic [AW-1:0] addr,
    input  logic [1:0]    size,
    output bmw_sel_e      sel,
    output logic [CW-1:0] ch,
    output logic [1:0]    lane,
    output logic          bad
);

    logic ptr_ok;

    always_comb begin
        ch     = addr[AW-1:3];
        lane   = addr[1:0];
        sel    = SEL_NONE;
        bad    = 1'b1;
        ptr_ok = 1'b0;
        if (!addr[2]) begin
            if (size == SZ_BYTE) begin
                bad = 1'b0;
                case (addr[1:0])
                    2'd0:    sel = SEL_CMD;
                    2'd1:    sel = SEL_MODE;
                    2'd2:    sel = SEL_STAT;
                    default: sel = SEL_TIME;
                endcase
            end
        end else begin
            case (size)
                SZ_BYTE: ptr_ok = 1'b1;
                SZ_HALF: ptr_ok = !addr[0];
                SZ_WORD: ptr_ok = (addr[1:0] == 2'd0);
                default: ptr_ok = 1'b0;
            endcase
            if (ptr_ok) begin
                sel = SEL_PTR;
                bad = 1'b0;
            end
        end
        if (32'(ch) >= N_CH) begin
            sel = SEL_NONE;
            bad = 1'b1;
        end
    end

endmodule

// File: rtl/bmw_mode.sv
`timescale 1ns/1ps
module bmw_mode
    import bmw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  bmw_sel_e   sel,
    input  logic [7:0] wbyte,
    output logic [7:0] mode_rd
);

    // only the two writable bits are kept
    logic [1:0] blk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            blk_q <= 2'b00;
        end else if (wr && sel == SEL_MODE) begin
            blk_q <= wbyte[5:4];
        end
    end

    assign mode_rd = {2'b00, blk_q, 4'b0000};

endmodule

// File: rtl/bmw_chan.sv
`timescale 1ns/1ps
module bmw_chan
    import bmw_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  bmw_sel_e      sel,
    input  logic [1:0]    lane,
    input  logic [1:0]    size,
    input  logic [DW-1:0] wdata,
    input  logic          act,
    input  logic          err_pulse,
    input  logic          irq_pulse,
    output logic [7:0]    cmd_q,
    output logic [7:0]    stat_rd,
    output logic [7:0]    time_q,
    output logic [DW-1:0] ptr_q
);

    logic [1:0]    rw_q;
    logic          err_q;
    logic          irq_q;
    logic          wr_stat;
    logic [3:0]    be;
    logic [DW-1:0] wsh;
    logic [DW-1:0] ptr_nx;

    assign wr_stat = wr && (sel == SEL_STAT);

    // byte enables and lane-shifted data for the descriptor address
    always_comb begin
        case (size)
            SZ_BYTE: be = 4'b0001 << lane;
            SZ_HALF: be = 4'b0011 << lane;
            default: be = 4'b1111;
        endcase
        wsh    = wdata << {lane, 3'b000};
        ptr_nx = ptr_q;
        for (int b = 0; b < 4; b++) begin
            if (be[b]) ptr_nx[8*b +: 8] = wsh[8*b +: 8];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q  <= 8'h00;
            time_q <= 8'h00;
            rw_q   <= 2'b00;
            err_q  <= 1'b0;
            irq_q  <= 1'b0;
            ptr_q  <= '0;
        end else begin
            if (wr && sel == SEL_CMD)  cmd_q  <= wdata[7:0];
            if (wr && sel == SEL_TIME) time_q <= wdata[7:0];
            if (wr_stat)               rw_q   <= wdata[6:5];
            // a set pulse wins over a write-one-to-clear in the same cycle
            err_q <= err_pulse | (err_q & ~(wr_stat & wdata[1]));
            irq_q <= irq_pulse | (irq_q & ~(wr_stat & wdata[2]));
            if (wr && sel == SEL_PTR)  ptr_q  <= {ptr_nx[DW-1:2], 2'b00};
        end
    end

    assign stat_rd = {1'b0, rw_q, 2'b00, irq_q, err_q, act};

endmodule

// File: rtl/bmw_regwin.sv
`timescale 1ns/1ps
module bmw_regwin
    import bmw_pkg::*;
#(
    parameter int N_CH = 2,
    localparam int CW = (N_CH > 1) ? $clog2(N_CH) : 1,
    localparam int AW = CW + 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   io_addr,
    input  logic [1:0]      io_size,
    input  logic            io_rd,
    input  logic            io_wr,
    input  logic [DW-1:0]   io_wdata,
    output logic [DW-1:0]   io_rdata,
    output logic            io_rvalid,
    input  logic [N_CH-1:0] eng_active,
    input  logic [N_CH-1:0] err_set,
    input  logic [N_CH-1:0] irq_set,
    output logic [N_CH-1:0] cmd_wstb,
    output logic [7:0]      cmd_wdata
);

    bmw_sel_e      sel;
    logic [CW-1:0] ch;
    logic [1:0]    lane;
    logic          bad;

    logic [7:0]    cmd_a  [N_CH];
    logic [7:0]    stat_a [N_CH];
    logic [7:0]    time_a [N_CH];
    logic [DW-1:0] ptr_a  [N_CH];
    logic [7:0]    mode_rd;

    logic [DW-1:0] rd_val;
    logic [N_CH-1:0] stb_nx;

    bmw_decode #(.N_CH(N_CH)) u_dec (
        .addr (io_addr),
        .size (io_size),
        .sel  (sel),
        .ch   (ch),
        .lane (lane),
        .bad  (bad)
    );

    bmw_mode u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (io_wr),
        .sel     (sel),
        .wbyte   (io_wdata[7:0]),
        .mode_rd (mode_rd)
    );

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        logic wr_c;
        assign wr_c = io_wr && (32'(ch) == c);
        bmw_chan u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr        (wr_c),
            .sel       (sel),
            .lane      (lane),
            .size      (io_size),
            .wdata     (io_wdata),
            .act       (eng_active[c]),
            .err_pulse (err_set[c]),
            .irq_pulse (irq_set[c]),
            .cmd_q     (cmd_a[c]),
            .stat_rd   (stat_a[c]),
            .time_q    (time_a[c]),
            .ptr_q     (ptr_a[c])
        );
    end

    // read data selection
    always_comb begin
        rd_val = size_ones(io_size);
        if (!bad) begin
            case (sel)
                SEL_CMD:  rd_val = {24'd0, cmd_a[ch]};
                SEL_MODE: rd_val = {24'd0, mode_rd};
                SEL_STAT: rd_val = {24'd0, stat_a[ch]};
                SEL_TIME: rd_val = {24'd0, time_a[ch]};
                SEL_PTR:  rd_val = (ptr_a[ch] >> {lane, 3'b000}) & size_ones(io_size);
                default:  rd_val = size_ones(io_size);
            endcase
        end
    end

    always_comb begin
        stb_nx = '0;
        if (io_wr && sel == SEL_CMD) stb_nx[ch] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            io_rvalid <= 1'b0;
            io_rdata  <= '0;
            cmd_wstb  <= '0;
            cmd_wdata <= 8'h00;
        end else begin
            io_rvalid <= io_rd;
            if (io_rd) io_rdata <= rd_val;
            cmd_wstb <= stb_nx;
            if (io_wr && sel == SEL_CMD) cmd_wdata <= io_wdata[7:0];
        end
    end

endmodule

// File: rtl/bmw_regwin_chk.sv
`timescale 1ns/1ps
module bmw_regwin_chk #(
    parameter int N_CH = 2,
    localparam int CW = (N_CH > 1) ? $clog2(N_CH) : 1,
    localparam int AW = CW + 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic [AW-1:0]   io_addr,
    input logic [1:0]      io_size,
    input logic            io_rd,
    input logic            io_wr,
    input logic [31:0]     io_wdata,
    input logic [31:0]     io_rdata,
    input logic            io_rvalid,
    input logic [N_CH-1:0] eng_active,
    input logic [N_CH-1:0] cmd_wstb,
    input logic [7:0]      cmd_wdata
);

    logic cmd_wr_seen;
    logic stat_rd_seen;
    assign cmd_wr_seen  = io_wr && io_size == 2'd0 && io_addr[2:0] == 3'd0
                          && 32'(io_addr[AW-1:3]) < N_CH;
    assign stat_rd_seen = io_rd && io_size == 2'd0 && io_addr[2:0] == 3'd2
                          && 32'(io_addr[AW-1:3]) < N_CH;

    // R2
    rd_gives_rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        io_rd |=> io_rvalid);

    // R2
    no_stray_rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !io_rd |=> !io_rvalid);

    // R4
    cmd_stb_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cmd_wstb));

    // R4
    cmd_stb_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr_seen |=> (cmd_wstb != '0) && (cmd_wdata == $past(io_wdata[7:0])));

    // R4
    no_stb_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_wr_seen |=> cmd_wstb == '0);

    // R3
    wide_ctrl_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && !io_addr[2] && io_size == 2'd2) |=> io_rdata == 32'hFFFF_FFFF);

    // R10
    ptr_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && io_size == 2'd2 && io_addr[2:0] == 3'd4 && 32'(io_addr[AW-1:3]) < N_CH)
        |=> io_rdata[1:0] == 2'b00);

    // R7
    stat_zero_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd_seen |=> (io_rdata[31:7] == '0) && (io_rdata[4:3] == 2'b00));

    // R7
    stat_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd_seen |=> io_rdata[0] == $past(eng_active[io_addr[AW-1:3]]));

endmodule

bind bmw_regwin bmw_regwin_chk #(.N_CH(N_CH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .io_addr    (io_addr),
    .io_size    (io_size),
    .io_rd      (io_rd),
    .io_wr      (io_wr),
    .io_wdata   (io_wdata),
    .io_rdata   (io_rdata),
    .io_rvalid  (io_rvalid),
    .eng_active (eng_active),
    .cmd_wstb   (cmd_wstb),
    .cmd_wdata  (cmd_wdata)
);

// File: tb/tb_bmw_regwin.sv
`timescale 1ns/1ps
module tb_bmw_regwin;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  io_addr = '0;
    logic [1:0]  io_size = '0;
    logic        io_rd = 1'b0;
    logic        io_wr = 1'b0;
    logic [31:0] io_wdata = '0;
    logic [31:0] io_rdata;
    logic        io_rvalid;
    logic [1:0]  eng_active = '0;
    logic [1:0]  err_set = '0;
    logic [1:0]  irq_set = '0;
    logic [1:0]  cmd_wstb;
    logic [7:0]  cmd_wdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    bmw_regwin #(.N_CH(2)) dut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_size(io_size),
        .io_rd(io_rd), .io_wr(io_wr), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .io_rvalid(io_rvalid), .eng_active(eng_active), .err_set(err_set),
        .irq_set(irq_set), .cmd_wstb(cmd_wstb), .cmd_wdata(cmd_wdata)
    );

    task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [7:0]  m_cmd [2];
    logic [7:0]  m_tim [2];
    logic [1:0]  m_rw  [2];
    logic        m_err [2];
    logic        m_irq [2];
    logic [31:0] m_ptr [2];
    logic [1:0]  m_mode;
    logic        e_rv;
    logic [31:0] e_rd;
    logic [1:0]  e_stb;
    logic [7:0]  e_cwd;
    string       e_tag = "R2";
    int          mc, mo;

    function automatic logic [31:0] ones_of(input logic [1:0] s);
        if (s == 2'd0) return 32'hFF;
        if (s == 2'd1) return 32'hFFFF;
        return 32'hFFFF_FFFF;
    endfunction

    function automatic bit ptr_legal(input int o, input logic [1:0] s);
        if (s == 2'd0) return 1;
        if (s == 2'd1) return (o % 2) == 0;
        if (s == 2'd2) return o == 4;
        return 0;
    endfunction

    function automatic string tag_of(input int o, input logic [1:0] s);
        if (o < 4 && s != 2'd0) return "R3";
        if (o == 0) return "R4";
        if (o == 1) return "R5";
        if (o == 2) return "R6";
        if (o == 3) return "R9";
        if (ptr_legal(o, s)) return "R10";
        return "R11";
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 2; k++) begin
                m_cmd[k] = 0; m_tim[k] = 0; m_rw[k] = 0;
                m_err[k] = 0; m_irq[k] = 0; m_ptr[k] = 0;
            end
            m_mode = 0; e_rv = 0; e_rd = 0; e_stb = 0; e_cwd = 0;
        end else begin
            mc = int'(io_addr[3]);
            mo = int'(io_addr[2:0]);
            e_rv = io_rd;
            e_stb = 0;
            if (io_rd) begin
                e_tag = tag_of(mo, io_size);
                if (mo < 4) begin
                    if (io_size != 2'd0) e_rd = ones_of(io_size);
                    else if (mo == 0) e_rd = {24'd0, m_cmd[mc]};
                    else if (mo == 1) e_rd = {26'd0, m_mode, 4'd0} >> 0;
                    else if (mo == 2) e_rd = 32'(m_rw[mc]) * 32 + 32'(m_irq[mc]) * 4
                                           + 32'(m_err[mc]) * 2 + 32'(eng_active[mc]);
                    else e_rd = {24'd0, m_tim[mc]};
                end else if (ptr_legal(mo, io_size)) begin
                    e_rd = (m_ptr[mc] >> (8 * (mo - 4))) & ones_of(io_size);
                end else begin
                    e_rd = ones_of(io_size);
                end
            end
            if (io_wr) begin
                if (mo < 4) begin
                    if (io_size == 2'd0) begin
                        if (mo == 0) begin
                            m_cmd[mc] = io_wdata[7:0];
                            e_stb[mc] = 1'b1;
                            e_cwd = io_wdata[7:0];
                        end else if (mo == 1) begin
                            m_mode = io_wdata[5:4];
                        end else if (mo == 2) begin
                            m_rw[mc] = io_wdata[6:5];
                            if (io_wdata[1]) m_err[mc] = 0;
                            if (io_wdata[2]) m_irq[mc] = 0;
                        end else begin
                            m_tim[mc] = io_wdata[7:0];
                        end
                    end
                end else if (ptr_legal(mo, io_size)) begin
                    for (int k = 0; k < 4; k++) begin
                        if ((io_size == 2'd0 && k < 1) || (io_size == 2'd1 && k < 2) || io_size == 2'd2)
                            m_ptr[mc][8*(mo-4+k) +: 8] = io_wdata[8*k +: 8];
                    end
                    m_ptr[mc][1:0] = 2'b00;
                end
            end
            for (int k = 0; k < 2; k++) begin
                if (err_set[k]) m_err[k] = 1;
                if (irq_set[k]) m_irq[k] = 1;
            end
        end
    end

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk({31'd0, io_rvalid}, {31'd0, e_rv}, "R2 model rvalid");
            if (e_rv) chk(io_rdata, e_rd, {e_tag, " model rdata"});
            chk({30'd0, cmd_wstb}, {30'd0, e_stb}, "R4 model strobe");
            if (e_stb != 0) chk({24'd0, cmd_wdata}, {24'd0, e_cwd}, "R4 model cmd byte");
        end
    end

    // ---------------- stimulus ----------------
    task automatic access(input bit w, input bit r, input logic [3:0] a, input logic [1:0] s,
                          input logic [31:0] d, input logic [1:0] es, input logic [1:0] is);
        @(negedge clk);
        io_wr = w; io_rd = r; io_addr = a; io_size = s; io_wdata = d;
        err_set = es; irq_set = is;
        @(negedge clk);
        io_wr = 0; io_rd = 0; err_set = 0; irq_set = 0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [1:0] s, input logic [31:0] d);
        access(1, 0, a, s, d, 2'b00, 2'b00);
    endtask

    task automatic rd_chk(input logic [3:0] a, input logic [1:0] s, input logic [31:0] exp,
                          input string tag);
        access(0, 1, a, s, 32'd0, 2'b00, 2'b00);
        chk(io_rdata, exp, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk({31'd0, io_rvalid}, 32'd0, "R1 rvalid in reset");
        chk({30'd0, cmd_wstb}, 32'd0, "R1 strobe in reset");
        rst_n = 1'b1;

        // R1: reset values
        for (int a = 0; a < 16; a++) begin
            if (a % 8 < 4) rd_chk(4'(a), 2'd0, 32'd0, "R1 control byte");
        end
        rd_chk(4'd4, 2'd2, 32'd0, "R1 address ch0");
        rd_chk(4'd12, 2'd2, 32'd0, "R1 address ch1");

        // R2: valid lasts one cycle
        access(0, 1, 4'd0, 2'd0, 32'd0, 2'b00, 2'b00);
        chk({31'd0, io_rvalid}, 32'd1, "R2 rvalid after read");
        @(negedge clk);
        chk({31'd0, io_rvalid}, 32'd0, "R2 rvalid single cycle");

        // R4: command writes and strobes
        wr(4'd0, 2'd0, 32'hFFFF_FF09);
        chk({30'd0, cmd_wstb}, 32'd1, "R4 strobe ch0");
        chk({24'd0, cmd_wdata}, 32'h09, "R4 cmd byte ch0");
        @(negedge clk);
        chk({30'd0, cmd_wstb}, 32'd0, "R4 strobe one cycle");
        rd_chk(4'd0, 2'd0, 32'h09, "R4 command readback, R2 upper bits zero");
        wr(4'd8, 2'd0, 32'h01);
        chk({30'd0, cmd_wstb}, 32'd2, "R4 strobe ch1");
        rd_chk(4'd0, 2'd0, 32'h09, "R12 ch0 command kept");

        // R5: shared mode byte
        wr(4'd1, 2'd0, 32'hFF);
        rd_chk(4'd9, 2'd0, 32'h30, "R5 mode via ch1");
        wr(4'd9, 2'd0, 32'h10);
        rd_chk(4'd1, 2'd0, 32'h10, "R5 mode via ch0");

        // R6 / R8: status rules
        wr(4'd2, 2'd0, 32'h60);
        rd_chk(4'd2, 2'd0, 32'h60, "R6 writable bits");
        access(0, 0, 4'd0, 2'd0, 32'd0, 2'b01, 2'b01);
        rd_chk(4'd2, 2'd0, 32'h66, "R8 set pulses");
        rd_chk(4'd10, 2'd0, 32'h00, "R12 ch1 status untouched");
        wr(4'd2, 2'd0, 32'h02);
        rd_chk(4'd2, 2'd0, 32'h04, "R6 clear error only");
        wr(4'd2, 2'd0, 32'h64);
        rd_chk(4'd2, 2'd0, 32'h60, "R6 clear interrupt");

        // R7: active mirror and zero bits
        eng_active = 2'b01;
        wr(4'd2, 2'd0, 32'h99);
        rd_chk(4'd2, 2'd0, 32'h01, "R7 active and zero bits");
        rd_chk(4'd10, 2'd0, 32'h00, "R7 ch1 active low");
        eng_active = 2'b00;
        rd_chk(4'd2, 2'd0, 32'h00, "R7 active follows input");

        // R8: set wins over clear in same cycle
        access(1, 0, 4'd2, 2'd0, 32'h06, 2'b01, 2'b01);
        rd_chk(4'd2, 2'd0, 32'h06, "R8 set beats clear");

        // R9: timing bytes
        wr(4'd3, 2'd0, 32'hA5);
        wr(4'd11, 2'd0, 32'h5A);
        rd_chk(4'd3, 2'd0, 32'hA5, "R9 timing ch0");
        rd_chk(4'd11, 2'd0, 32'h5A, "R9 timing ch1");

        // R10: descriptor address
        wr(4'd12, 2'd2, 32'h1234_5677);
        rd_chk(4'd12, 2'd2, 32'h1234_5674, "R10 word with low bits zero");
        rd_chk(4'd13, 2'd0, 32'h56, "R10 byte lane 1");
        rd_chk(4'd14, 2'd1, 32'h1234, "R10 upper half");
        wr(4'd12, 2'd0, 32'hFF);
        rd_chk(4'd12, 2'd2, 32'h1234_56FC, "R10 byte write");
        wr(4'd6, 2'd1, 32'hBEEF);
        rd_chk(4'd4, 2'd2, 32'hBEEF_0000, "R10 half write ch0");
        rd_chk(4'd12, 2'd2, 32'h1234_56FC, "R12 ch1 address kept");

        // R3: wide control accesses
        rd_chk(4'd0, 2'd1, 32'h0000_FFFF, "R3 half read ones");
        rd_chk(4'd2, 2'd2, 32'hFFFF_FFFF, "R3 word read ones");
        rd_chk(4'd1, 2'd3, 32'hFFFF_FFFF, "R3 size 3 read ones");
        wr(4'd3, 2'd1, 32'h0000);
        rd_chk(4'd3, 2'd0, 32'hA5, "R3 wide write ignored");
        wr(4'd0, 2'd2, 32'h0000_0000);
        chk({30'd0, cmd_wstb}, 32'd0, "R3 no strobe on wide write");
        rd_chk(4'd0, 2'd0, 32'h09, "R3 command unchanged");

        // R11: misaligned address accesses
        rd_chk(4'd5, 2'd1, 32'h0000_FFFF, "R11 odd half read");
        rd_chk(4'd6, 2'd2, 32'hFFFF_FFFF, "R11 unaligned word read");
        rd_chk(4'd4, 2'd3, 32'hFFFF_FFFF, "R11 size 3 read");
        wr(4'd13, 2'd2, 32'h0);
        wr(4'd15, 2'd1, 32'h0);
        rd_chk(4'd12, 2'd2, 32'h1234_56FC, "R11 misaligned writes ignored");

        repeat (3) @(negedge clk);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule